// File: doc/BRIEF.md
# Configuration Register CRC Monitor

This block guards the integrity of a bank of eight 16-bit configuration words (word addresses 8 to 15 of a larger register file). When started, it takes a snapshot of the whole bank, runs an 8-bit CRC over every byte of the bank except the stored checksum byte, and compares the result with the checksum held in the low byte of the last word. A mismatch produces a one-cycle fail pulse that the surrounding status logic turns into a sticky configuration-CRC error bit.

The check can be switched off through an enable input. It is also suppressed whenever the 2-bit auto-calibration field of the first word in the bank is non-zero, since calibration rewrites that bank on its own. When a snapshot shows the auto-calibration field back at zero after the previous snapshot showed it non-zero, the block emits a one-cycle request to set the enable bit again, and treats that check as enabled.

The register file itself lies outside this block; it presents the bank as one flat bus and owns the enable bit.

Top module: `cfg_crc_monitor`

## Requirements
- R1: While reset is active and in the cycles after its release, `busy`, `crc_fail` and `en_set` are all 0.
- R2: The CRC uses polynomial 0x1D (x^8+x^4+x^3+x^2+1), starts from 0xFF, takes each byte MSB first, and its final value is inverted. The bytes are taken in this order: word 0 (bits 15:0 of `cfg_words`) high byte, then its low byte, then word 1 and so on up to word 7. Only the high byte of word 7 is included. The low byte of word 7 (bits 119:112) is the stored checksum and is excluded. When checksum and result agree, no fail is reported.
- R3: When the check is active and the result differs from the stored checksum, `crc_fail` is high for exactly one cycle: the first cycle in which `busy` is low again.
- R4: A start request while idle is accepted at that clock edge. `busy` is then high for exactly 15 cycles, one per processed byte, starting in the cycle after acceptance.
- R5: A start request while `busy` is high is ignored. A change of `cfg_words` after acceptance does not affect that check: the bank and the control inputs are captured at the accepting edge.
- R6: When `chk_en` is 0 at acceptance, no fail is reported, whatever the checksum.
- R7: When bits 1:0 of word 0 (the auto-calibration field) are non-zero at acceptance, no fail is reported, whatever `chk_en` or the checksum.
- R8: When the auto-calibration field captured at acceptance is zero and the one captured at the previous acceptance was non-zero, `en_set` is high for one cycle in the cycle after acceptance. That check then behaves as if `chk_en` were 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Request one check of the bank |
| chk_en | input | 1 | CRC check enable bit from the register file |
| cfg_words | input | 128 | Flat bank of words 0..7; word k in bits 16k+15:16k |
| busy | output | 1 | A check is in progress |
| crc_fail | output | 1 | One-cycle pulse: active check found a mismatch |
| en_set | output | 1 | One-cycle request to set the enable bit again |

## Verification
The assertions assume that `start` is a clean synchronous level: it may stay high or be pulsed at any time, busy or not. They also assume the bank bus can change at any cycle, since the capture at acceptance is what they guard. The bench drives every input at the falling edge, holds `start` high for one cycle, and changes `cfg_words` during a check only in the test that probes the capture. The auto-calibration field stays at zero in the sweeps, so the re-enable request appears only in the sequence built for it.

// File: rtl/cfg_crc_pkg.sv
package cfg_crc_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;

endpackage

// File: rtl/cfg_crc_step.sv
// One full chunk of the CRC, one unrolled stage per input bit, MSB first.
module cfg_crc_step #(
  parameter int          CRC_W = 8,
  parameter logic [7:0]  POLY  = 8'h1D
) (
  input  logic [CRC_W-1:0] crc_in,
  input  logic [CRC_W-1:0] chunk_in,
  output logic [CRC_W-1:0] crc_out
);

  logic [CRC_W-1:0] stage [0:CRC_W];

  assign stage[0] = crc_in ^ chunk_in;

  for (genvar b = 0; b < CRC_W; b++) begin : g_bit
    always_comb begin
      if (stage[b][CRC_W-1]) begin
        stage[b+1] = {stage[b][CRC_W-2:0], 1'b0} ^ POLY[CRC_W-1:0];
      end else begin
        stage[b+1] = {stage[b][CRC_W-2:0], 1'b0};
      end
    end
  end

  assign crc_out = stage[CRC_W];

endmodule

// File: rtl/cfg_crc_seq.sv
// Walks the chunk index from acceptance to the last covered chunk.
module cfg_crc_seq
  import cfg_crc_pkg::*;
#(
  parameter int NCHUNKS = 15,
  localparam int IDX_W  = (NCHUNKS > 1) ? $clog2(NCHUNKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             accept,
  output logic             busy,
  output logic             last,
  output logic [IDX_W-1:0] idx
);

  phase_e           phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  assign busy   = (phase_q == PH_RUN);
  assign accept = start && (phase_q == PH_IDLE);
  assign last   = busy && (idx_q == IDX_W'(NCHUNKS - 1));
  assign idx    = idx_q;

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    if (accept) begin
      phase_d = PH_RUN;
      idx_d   = '0;
    end else if (last) begin
      phase_d = PH_IDLE;
      idx_d   = '0;
    end else if (busy) begin
      idx_d   = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
    end
  end

  // R4: busy only rises on an accepted request
  assert_busy_from_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R4: busy only falls after the last chunk was processed
  assert_busy_ends_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(last));

endmodule

// File: rtl/cfg_crc_snap.sv
// Holds the captured bank and presents chunks in processing order.
module cfg_crc_snap #(
  parameter int NUM_WORDS = 8,
  parameter int WORD_W    = 16,
  parameter int CRC_W     = 8,
  localparam int BANK_W   = NUM_WORDS * WORD_W,
  localparam int CPW      = WORD_W / CRC_W,
  localparam int NCHUNKS  = NUM_WORDS * CPW - 1,
  localparam int IDX_W    = (NCHUNKS > 1) ? $clog2(NCHUNKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [BANK_W-1:0] bank_in,
  input  logic [IDX_W-1:0]  idx,
  output logic [CRC_W-1:0]  chunk,
  output logic [CRC_W-1:0]  stored_crc
);

  logic [BANK_W-1:0] bank_q, bank_d;
  logic [CRC_W-1:0]  chunk_arr [0:NCHUNKS-1];

  always_comb begin
    bank_d = bank_q;
    if (cap_en) begin
      bank_d = bank_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
    end else begin
      bank_q <= bank_d;
    end
  end

  // chunk k: word k/CPW, most significant chunk of a word first
  for (genvar k = 0; k < NCHUNKS; k++) begin : g_chunk
    localparam int OFS = (k / CPW) * WORD_W + (CPW - 1 - (k % CPW)) * CRC_W;
    assign chunk_arr[k] = bank_q[OFS +: CRC_W];
  end

  assign chunk      = chunk_arr[idx];
  assign stored_crc = bank_q[(NUM_WORDS-1)*WORD_W +: CRC_W];

endmodule

// File: rtl/cfg_crc_monitor.sv
module cfg_crc_monitor #(
  parameter int         NUM_WORDS = 8,
  parameter int         WORD_W    = 16,
  parameter int         CRC_W     = 8,
  parameter logic [7:0] POLY      = 8'h1D,
  parameter logic [7:0] INIT      = 8'hFF,
  parameter logic [7:0] XOROUT    = 8'hFF,
  parameter int         AC_LSB    = 0,
  parameter int         AC_W      = 2,
  localparam int BANK_W  = NUM_WORDS * WORD_W,
  localparam int NCHUNKS = NUM_WORDS * (WORD_W / CRC_W) - 1,
  localparam int IDX_W   = (NCHUNKS > 1) ? $clog2(NCHUNKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              chk_en,
  input  logic [BANK_W-1:0] cfg_words,
  output logic              busy,
  output logic              crc_fail,
  output logic              en_set
);

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic             accept, last;
  logic [IDX_W-1:0] idx;
  logic [CRC_W-1:0] chunk, stored_crc, step_out, final_crc;

  cfg_crc_seq #(.NCHUNKS(NCHUNKS)) u_seq (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .start  (start),
    .accept (accept),
    .busy   (busy),
    .last   (last),
    .idx    (idx)
  );

  cfg_crc_snap #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .CRC_W(CRC_W)) u_snap (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cap_en     (accept),
    .bank_in    (cfg_words),
    .idx        (idx),
    .chunk      (chunk),
    .stored_crc (stored_crc)
  );

  logic [CRC_W-1:0] crc_q, crc_d;

  cfg_crc_step #(.CRC_W(CRC_W), .POLY(POLY)) u_step (
    .crc_in   (crc_q),
    .chunk_in (chunk),
    .crc_out  (step_out)
  );

  assign final_crc = step_out ^ XOROUT[CRC_W-1:0];

  // enable decision, taken at the accepting edge
  logic ac_nz_now, reassert_now;
  logic prev_ac_nz_q, prev_ac_nz_d;
  logic act_q, act_d;
  logic fail_q, fail_d;
  logic en_set_q, en_set_d;

  assign ac_nz_now    = |cfg_words[AC_LSB +: AC_W];
  assign reassert_now = prev_ac_nz_q && !ac_nz_now;

  always_comb begin
    crc_d        = crc_q;
    prev_ac_nz_d = prev_ac_nz_q;
    act_d        = act_q;
    en_set_d     = 1'b0;
    fail_d       = 1'b0;
    if (accept) begin
      crc_d        = INIT[CRC_W-1:0];
      prev_ac_nz_d = ac_nz_now;
      act_d        = (chk_en || reassert_now) && !ac_nz_now;
      en_set_d     = reassert_now;
    end else if (busy) begin
      crc_d = step_out;
      if (last) begin
        fail_d = act_q && (final_crc != stored_crc);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      crc_q        <= '0;
      prev_ac_nz_q <= 1'b0;
      act_q        <= 1'b0;
      en_set_q     <= 1'b0;
      fail_q       <= 1'b0;
    end else begin
      crc_q        <= crc_d;
      prev_ac_nz_q <= prev_ac_nz_d;
      act_q        <= act_d;
      en_set_q     <= en_set_d;
      fail_q       <= fail_d;
    end
  end

  assign crc_fail = fail_q;
  assign en_set   = en_set_q;

  // R3: a fail appears only in the first idle cycle after a check
  assert_fail_at_end_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    crc_fail |-> (!busy && $past(busy)));

  // R3: a fail lasts one cycle
  assert_fail_pulse_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    crc_fail |=> !crc_fail);

  // R5: a request during a check leaves the captured bank alone
  assert_busy_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && start) |=> $stable(stored_crc));

  // R8: the re-enable request coincides with the first busy cycle
  assert_enset_first_busy_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    en_set |-> (busy && !$past(busy)));

  // R1: nothing is reported while reset is held
  always_comb begin
    if (!rst_sync_n) begin
      assert_idle_in_reset_R1: assert (!crc_fail && !en_set);
    end
  end

endmodule

// File: tb/cfg_crc_monitor_tb.sv
module cfg_crc_monitor_tb;

  localparam int NW = 8;
  localparam int WW = 16;
  localparam int BW = NW * WW;
  localparam int NBYTES = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic chk_en = 1'b1;
  logic [BW-1:0] cfg_words = '0;
  logic busy, crc_fail, en_set;

  int n_cmp = 0;
  int n_bad = 0;
  logic m_prev_ac_nz = 1'b0;

  always #4 clk = ~clk;

  cfg_crc_monitor u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .chk_en    (chk_en),
    .cfg_words (cfg_words),
    .busy      (busy),
    .crc_fail  (crc_fail),
    .en_set    (en_set)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bytes: word0 high, word0 low, ... word7 high; poly 0x1D, init FF, out inverted
  function automatic logic [7:0] ref_crc(input logic [BW-1:0] bank);
    logic [7:0] c = 8'hFF;
    for (int k = 0; k < NBYTES; k++) begin
      int ofs = (k / 2) * WW + (1 - (k % 2)) * 8;
      c = c ^ bank[ofs +: 8];
      for (int b = 0; b < 8; b++) begin
        c = c[7] ? ((c << 1) ^ 8'h1D) : (c << 1);
      end
    end
    return c ^ 8'hFF;
  endfunction

  function automatic logic [BW-1:0] seal(input logic [BW-1:0] bank);
    logic [BW-1:0] r = bank;
    r[(NW-1)*WW +: 8] = ref_crc(bank);
    return r;
  endfunction

  // one full check; mid_idx >= 0 injects a second start and a bank change
  task automatic run(input logic [BW-1:0] bank, input logic en, input string req,
                     input int mid_idx, input logic [BW-1:0] other);
    logic ac_nz, reass, act, exp_fail;
    ac_nz    = |bank[1:0];
    reass    = m_prev_ac_nz && !ac_nz;
    act      = (en || reass) && !ac_nz;
    exp_fail = act && (ref_crc(bank) != bank[(NW-1)*WW +: 8]);
    m_prev_ac_nz = ac_nz;
    @(negedge clk);
    cfg_words = bank;
    chk_en    = en;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({req, " R8 en_set"}, en_set, reass);
    check({req, " R4 busy"}, busy, 1'b1);
    for (int i = 1; i < NBYTES; i++) begin
      if (i == mid_idx) begin
        start     = 1'b1;
        cfg_words = other;
        chk_en    = ~en;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      check({req, " R4 busy held"}, busy, 1'b1);
      check({req, " R3 no early fail"}, crc_fail, 1'b0);
    end
    start = 1'b0;
    @(negedge clk);
    check({req, " R4 busy low"}, busy, 1'b0);
    check({req, " fail"}, crc_fail, exp_fail);
    @(negedge clk);
    check({req, " R3 fail pulse"}, crc_fail, 1'b0);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual expired expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    logic [BW-1:0] b;
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", busy, 1'b0);
    check("R1 fail in reset", crc_fail, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 busy after reset", busy, 1'b0);
    check("R1 fail after reset", crc_fail, 1'b0);
    check("R1 en_set after reset", en_set, 1'b0);

    // R2: all-zero and all-ones data, sealed
    run(seal('0), 1'b1, "R2 zeros", -1, '0);
    b = '1; b[1:0] = 2'b00;
    run(seal(b), 1'b1, "R2 ones", -1, '0);

    // R2/R3: walking bit over every covered data bit (auto-cal field kept zero)
    for (int k = 2; k < BW; k++) begin
      if (k >= (NW-1)*WW && k < (NW-1)*WW + 8) continue;
      b = '0; b[k] = 1'b1;
      b = seal(b);
      run(b, 1'b1, "R2 walk sealed", -1, '0);
      b[(NW-1)*WW + (k % 8)] = ~b[(NW-1)*WW + (k % 8)];
      run(b, 1'b1, "R3 walk corrupt", -1, '0);
    end

    // R2/R3: pseudo-random banks
    lf = 32'h1ACE_B00C;
    for (int n = 0; n < 24; n++) begin
      for (int w = 0; w < BW / 32; w++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        b[w*32 +: 32] = lf * 32'd2654435761;
      end
      b[1:0] = 2'b00;
      if (n % 2 == 0) run(seal(b), 1'b1, "R2 random sealed", -1, '0);
      else begin
        b = seal(b);
        b[(NW-1)*WW +: 8] = b[(NW-1)*WW +: 8] ^ 8'(n);
        run(b, 1'b1, "R3 random corrupt", -1, '0);
      end
    end

    // R5: second start mid-check with a different bank is ignored
    b = '0; b[40] = 1'b1;
    run(seal(b), 1'b1, "R5 ignore sealed", 6, '1);
    b = seal(b); b[(NW-1)*WW] = ~b[(NW-1)*WW];
    run(b, 1'b1, "R5 ignore corrupt", 9, seal('0));

    // R6: disabled check never fails
    b = '0; b[77] = 1'b1; b[(NW-1)*WW +: 8] = 8'h5A;
    run(b, 1'b0, "R6 disabled", -1, '0);

    // R7: non-zero auto-calibration field suppresses the check
    for (int a = 1; a < 4; a++) begin
      b = '0; b[1:0] = 2'(a); b[(NW-1)*WW +: 8] = 8'hC3;
      run(b, 1'b1, "R7 autocal", -1, '0);
    end

    // R8: autocal back to zero re-enables once, even with chk_en low
    b = '0; b[20] = 1'b1; b[(NW-1)*WW +: 8] = 8'h00;
    if (ref_crc(b) == 8'h00) b[(NW-1)*WW +: 8] = 8'h01;
    run(b, 1'b0, "R8 reenable", -1, '0);
    run(b, 1'b0, "R8 no repeat", -1, '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule